// File: doc/BRIEF.md
# SEC-DED Protected Word Memory

This block wraps a 64-bit synchronous RAM with single-error-correct, double-error-detect protection. Each location holds 72 bits: 64 data bits and 8 check bits. The check bits are seven Hamming bits and one overall parity bit, and a fixed pattern is XORed into them before they are stored. A write with all eight byte enables set encodes the new data and stores it straight away. It never looks at the old contents, so it is the way to bring up memory whose check bits are random after power-on. A write with fewer byte enables is a read-modify-write. The old word is fetched and checked, the enabled bytes are merged in, and the word is re-encoded and written back.

Reads return corrected data. The error indication arrives in the same cycle as the data. A stored word whose 72 raw bits are all zero or all one is treated as a hard failure, whatever its syndrome says. Two sticky flags, one for corrected errors and one for uncorrectable errors, record what happened. The address of the first error is kept until both flags have been cleared. A backdoor port writes and reads raw 72-bit words, so a test can place corruptions in the array.

Top module: `secded_ram`

## Requirements
- R1: After reset, reqReady is 1, rspValid is 0 and both sticky flags are 0. A full write (reqBe = 8'hFF) followed by a read returns the written data with rspErr = 0 and rspCorr = 0. This includes the data values all-zero and all-one.
- R2: If any one of the 72 stored bits is flipped, a read returns the original data with rspCorr = 1 and rspErr = 0, and stickyCe is set.
- R3: If any two of the 72 stored bits are flipped, a read returns rspErr = 1 and rspCorr = 0, and stickyUe is set.
- R4: A stored raw word of 72 zeros or 72 ones makes a read return rspErr = 1, and stickyUe is set.
- R5: A plain read never writes the array. After a corrected read, the raw stored word is still the corrupted one.
- R6: A write with reqBe != 8'hFF holds reqReady low for exactly one cycle while the old word is read. The requester keeps the request stable during that cycle. Afterwards, bytes whose bit in reqBe is 1 take the new data and the other bytes keep their old value.
- R7: If the read phase of a read-modify-write finds a single-bit error, the write-back stores a clean word. The write response has rspCorr = 1 and stickyCe is set, and a later read returns the merged data with rspCorr = 0.
- R8: If the read phase of a read-modify-write finds an uncorrectable error, the write is dropped. The response has rspErr = 1, the raw stored word is unchanged, and stickyUe is set.
- R9: errAddr takes the address of an error only when both sticky flags are clear. It holds that value while either flag is set.
- R10: A one-cycle pulse on clrCe clears only stickyCe, and a pulse on clrUe clears only stickyUe. A flag stays set until its clear pulse arrives.
- R11: A full write to a location holding a corrupted word, even an all-zero word, responds with rspErr = 0. The location then reads back clean.
- R12: Each accepted request (reqValid and reqReady high at a clock edge) gives exactly one rspValid pulse, in the cycle right after acceptance. For a read, the data, rspErr and rspCorr are valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, synchronous |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqBe | input | 8 | Byte enables for writes; bit b selects data bits 8b+7..8b |
| reqWdata | input | 64 | Write data |
| reqReady | output | 1 | Request accepted at this edge when high |
| rspValid | output | 1 | Response cycle |
| rspRdata | output | 64 | Corrected read data (zero for write responses) |
| rspErr | output | 1 | Uncorrectable or hard error on this access |
| rspCorr | output | 1 | Single-bit error corrected on this access |
| clrCe | input | 1 | Clear pulse for stickyCe |
| clrUe | input | 1 | Clear pulse for stickyUe |
| stickyCe | output | 1 | A corrected error has been seen |
| stickyUe | output | 1 | An uncorrectable error has been seen |
| errAddr | output | ADDR_W | Address of the first error |
| bdWe | input | 1 | Backdoor raw write strobe |
| bdAddr | input | ADDR_W | Backdoor address |
| bdWdata | input | 72 | Backdoor raw word to store |
| bdRdata | output | 72 | Raw stored word at bdAddr |

## Verification
The decoder is driven with a single flip at each of the 72 bit positions. This separates data-bit correction from flips that land on a Hamming bit or on the parity bit. Double flips spread over data, check and parity bits show that no pair is mistaken for a correctable error. Raw words of all zeros and all ones show that the hard-error path fires even with a zero syndrome. Full writes of all-zero and all-one data show that the stored check mask keeps legal words away from those patterns. Read-modify-writes with several byte-enable patterns (single low byte, single high byte, inner bytes, none) are run on clean words, on words with one flip and on words with two flips. These cases separate a plain merge, a silent repair and an aborted write that leaves the raw word untouched.

// File: rtl/secded_pkg.sv
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int HAM_W  = CHK_W - 1;
  localparam int WORD_W = DATA_W + CHK_W;
  localparam int LANES  = DATA_W / 8;
  localparam int SPAN   = DATA_W + HAM_W;
  localparam int IDX_W  = $clog2(DATA_W);
  // XORed into stored check bits so that all-zero / all-one words are never legal
  localparam logic [CHK_W-1:0] CHK_MASK = 8'hA5;

  typedef struct packed {
    logic ramRead;
    logic ramWrite;
    logic readAcc;
    logic fullAcc;
    logic mergeCycle;
  } strobe_t;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic ce;
    logic ue;
  } dec_t;

  // Hamming bits: data bits sit at the non-power-of-two positions 3..SPAN
  function automatic logic [HAM_W-1:0] hamCalc(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] c;
    logic [IDX_W-1:0] j;
    c = '0;
    j = '0;
    for (int p = 1; p <= SPAN; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int i = 0; i < HAM_W; i++)
          if (p[i]) c[i] ^= d[j];
        j++;
      end
    end
    return c;
  endfunction

  function automatic logic [WORD_W-1:0] encode(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    logic par;
    h   = hamCalc(d);
    par = (^d) ^ (^h);
    return {({par, h} ^ CHK_MASK), d};
  endfunction

  function automatic dec_t decode(input logic [WORD_W-1:0] w);
    dec_t r;
    logic [CHK_W-1:0] c;
    logic [HAM_W-1:0] s;
    logic ov;
    logic [IDX_W-1:0] j;
    c = w[WORD_W-1:DATA_W] ^ CHK_MASK;
    r.data = w[DATA_W-1:0];
    r.ce = 1'b0;
    r.ue = 1'b0;
    s  = hamCalc(r.data) ^ c[HAM_W-1:0];
    ov = (^r.data) ^ (^c);
    if (w == '0 || &w) begin
      r.ue = 1'b1;
    end else if (ov) begin
      if (s > HAM_W'(SPAN)) begin
        r.ue = 1'b1;
      end else begin
        r.ce = 1'b1;
        j = '0;
        for (int p = 1; p <= SPAN; p++) begin
          if ((p & (p - 1)) != 0) begin
            if (HAM_W'(p) == s) r.data[j] = ~r.data[j];
            j++;
          end
        end
      end
    end else if (s != '0) begin
      r.ue = 1'b1;
    end
    return r;
  endfunction
endpackage

// File: rtl/secded_store.sv
module secded_store import secded_pkg::*; #(
  parameter int DEPTH  = 32,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [WORD_W-1:0] bdWdata,
  output logic [WORD_W-1:0] bdRdata
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[addr] <= wdata;
    if (bdWe) mem[bdAddr] <= bdWdata;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdata <= '0;
    else if (rdEn) rdata <= mem[addr];
  end

  assign bdRdata = mem[bdAddr];

  // R6: the single port is never asked to read and write in one cycle
  p_port_excl_r6: assert property (@(posedge clk) disable iff (!rstN) rdEn |-> !wrEn);
endmodule

// File: rtl/secded_ctrl.sv
module secded_ctrl import secded_pkg::*; (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [LANES-1:0] reqBe,
  input  logic             decUe,
  output logic             reqReady,
  output strobe_t          strb
);
  typedef enum logic {S_IDLE, S_MERGE} state_t;
  state_t state, nextState;
  logic isFull;

  assign isFull = &reqBe;

  always_comb begin
    strb      = '0;
    nextState = state;
    reqReady  = 1'b1;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (!reqWrite) begin
            strb.ramRead = 1'b1;
            strb.readAcc = 1'b1;
          end else if (isFull) begin
            strb.ramWrite = 1'b1;
            strb.fullAcc  = 1'b1;
          end else begin
            strb.ramRead = 1'b1;
            reqReady     = 1'b0;
            nextState    = S_MERGE;
          end
        end
      end
      S_MERGE: begin
        strb.mergeCycle = 1'b1;
        strb.ramWrite   = !decUe;
        nextState       = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  // R6: the merge phase lasts one cycle and a partial write is accepted right after its stall
  p_merge_one_cycle_r6: assert property (@(posedge clk) disable iff (!rstN)
    state == S_MERGE |=> state == S_IDLE);
  p_partial_stall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && reqValid && reqWrite && !isFull) |=> reqReady);
endmodule

// File: rtl/secded_path.sv
module secded_path import secded_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [WORD_W-1:0] memRd,
  input  logic              clrCe,
  input  logic              clrUe,
  output logic              decUe,
  output logic [WORD_W-1:0] ramWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              rspCorr,
  output logic              stickyCe,
  output logic              stickyUe,
  output logic [ADDR_W-1:0] errAddr
);
  dec_t dec;
  logic [DATA_W-1:0] mergedData;
  logic rdPend, wrDone, errQ, corrQ;
  logic [ADDR_W-1:0] rdAddrQ, srcAddr;
  logic checking, evCe, evUe;

  assign dec   = decode(memRd);
  assign decUe = dec.ue;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign mergedData[b*8 +: 8] = reqBe[b] ? reqWdata[b*8 +: 8] : dec.data[b*8 +: 8];
  end

  assign ramWdata = encode(strb.mergeCycle ? mergedData : reqWdata);

  assign checking = rdPend | strb.mergeCycle;
  assign evCe     = checking & dec.ce;
  assign evUe     = checking & dec.ue;
  assign srcAddr  = rdPend ? rdAddrQ : reqAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPend   <= 1'b0;
      wrDone   <= 1'b0;
      errQ     <= 1'b0;
      corrQ    <= 1'b0;
      rdAddrQ  <= '0;
      stickyCe <= 1'b0;
      stickyUe <= 1'b0;
      errAddr  <= '0;
    end else begin
      rdPend <= strb.readAcc;
      wrDone <= strb.fullAcc | strb.mergeCycle;
      errQ   <= strb.mergeCycle & dec.ue;
      corrQ  <= strb.mergeCycle & dec.ce;
      if (strb.readAcc) rdAddrQ <= reqAddr;
      if (evCe)       stickyCe <= 1'b1;
      else if (clrCe) stickyCe <= 1'b0;
      if (evUe)       stickyUe <= 1'b1;
      else if (clrUe) stickyUe <= 1'b0;
      if ((evCe | evUe) && !stickyCe && !stickyUe) errAddr <= srcAddr;
    end
  end

  assign rspValid = rdPend | wrDone;
  assign rspRdata = rdPend ? dec.data : '0;
  assign rspErr   = rdPend ? dec.ue : errQ;
  assign rspCorr  = rdPend ? dec.ce : corrQ;

  // R8: an uncorrectable old word never leads to a write-back
  p_ue_blocks_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.mergeCycle && dec.ue) |-> !strb.ramWrite);
  // R4: a raw all-zero or all-one word always reports an error on a read
  p_hard_word_r4: assert property (@(posedge clk) disable iff (!rstN)
    (rdPend && (memRd == '0 || &memRd)) |-> rspErr);
  // R3: a response never claims both a correction and a failure
  p_err_excl_r3: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> !(rspErr && rspCorr));
  // R10: flags hold until their own clear pulse
  p_ce_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stickyCe && !clrCe) |=> stickyCe);
  p_ue_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (stickyUe && !clrUe) |=> stickyUe);
  // R9: the captured address is frozen while any flag is set
  p_addr_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    (stickyCe || stickyUe) |=> $stable(errAddr));
endmodule

// File: rtl/secded_ram.sv
module secded_ram import secded_pkg::*; #(
  parameter  int DEPTH  = 32,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]  reqBe,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic              rspErr,
  output logic              rspCorr,
  input  logic              clrCe,
  input  logic              clrUe,
  output logic              stickyCe,
  output logic              stickyUe,
  output logic [ADDR_W-1:0] errAddr,
  input  logic              bdWe,
  input  logic [ADDR_W-1:0] bdAddr,
  input  logic [WORD_W-1:0] bdWdata,
  output logic [WORD_W-1:0] bdRdata
);
  strobe_t strb;
  logic decUe;
  logic [WORD_W-1:0] memRd, ramWdata;

  secded_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBe(reqBe), .decUe(decUe), .reqReady(reqReady), .strb(strb)
  );

  secded_path #(.ADDR_W(ADDR_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqBe(reqBe),
    .reqWdata(reqWdata), .memRd(memRd), .clrCe(clrCe), .clrUe(clrUe),
    .decUe(decUe), .ramWdata(ramWdata), .rspValid(rspValid), .rspRdata(rspRdata),
    .rspErr(rspErr), .rspCorr(rspCorr), .stickyCe(stickyCe), .stickyUe(stickyUe),
    .errAddr(errAddr)
  );

  secded_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .rstN(rstN), .rdEn(strb.ramRead), .wrEn(strb.ramWrite),
    .addr(reqAddr), .wdata(ramWdata), .rdata(memRd), .bdWe(bdWe),
    .bdAddr(bdAddr), .bdWdata(bdWdata), .bdRdata(bdRdata)
  );
endmodule

// File: tb/sim_secded_ram.sv
module sim_secded_ram;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [7:0] reqBe = '0;
  logic [63:0] reqWdata = '0;
  logic reqReady, rspValid, rspErr, rspCorr;
  logic [63:0] rspRdata;
  logic clrCe = 1'b0, clrUe = 1'b0;
  logic stickyCe, stickyUe;
  logic [AW-1:0] errAddr;
  logic bdWe = 1'b0;
  logic [AW-1:0] bdAddr = '0;
  logic [71:0] bdWdata = '0;
  logic [71:0] bdRdata;

  int nChk = 0, nFail = 0;
  bit finished = 0;
  logic [63:0] shadow [DEPTH];

  typedef struct {
    logic [63:0] data;
    logic err, corr, chkData;
    string tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  secded_ram #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqBe(reqBe), .reqWdata(reqWdata), .reqReady(reqReady), .rspValid(rspValid),
    .rspRdata(rspRdata), .rspErr(rspErr), .rspCorr(rspCorr), .clrCe(clrCe), .clrUe(clrUe),
    .stickyCe(stickyCe), .stickyUe(stickyUe), .errAddr(errAddr), .bdWe(bdWe),
    .bdAddr(bdAddr), .bdWdata(bdWdata), .bdRdata(bdRdata)
  );

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input int a);
    return {32'(a) * 32'h9E3779B9, ~(32'(a) * 32'h7F4A7C15)};
  endfunction

  function automatic logic [63:0] mergeExp(input logic [63:0] old, input logic [63:0] nw,
                                           input logic [7:0] be);
    logic [63:0] r;
    r = old;
    for (int b = 0; b < 8; b++) if (be[b]) r[b*8 +: 8] = nw[b*8 +: 8];
    return r;
  endfunction

  // Monitor: R12, one response right after each acceptance
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      nChk++;
      if (expQ.size() == 0) begin
        nFail++;
        $display("FAIL R12: unexpected response, actual rspValid 1 expected 0");
      end else begin
        exp_t e;
        e = expQ.pop_front();
        if (rspErr !== e.err || rspCorr !== e.corr || (e.chkData && rspRdata !== e.data)) begin
          nFail++;
          $display("FAIL %s: actual data %h err %b corr %b expected data %h err %b corr %b",
                   e.tag, rspRdata, rspErr, rspCorr, e.data, e.err, e.corr);
        end
      end
    end
  end

  task automatic doReq(input logic wr, input int a, input logic [7:0] be, input logic [63:0] wd,
                       input logic [63:0] eData, input logic eErr, input logic eCorr,
                       input logic eChk, input string tag);
    int stall;
    exp_t e;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = AW'(a); reqBe = be; reqWdata = wd;
    #1;
    stall = 0;
    while (!reqReady && stall < 10) begin
      stall++;
      @(negedge clk);
      #1;
    end
    check({tag, " R6 stall"}, 72'(stall), (wr && be != 8'hFF) ? 72'd1 : 72'd0);
    e.data = eData; e.err = eErr; e.corr = eCorr; e.chkData = eChk; e.tag = tag;
    expQ.push_back(e);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    check("R12 all responses seen", 72'(expQ.size()), 72'd0);
  endtask

  task automatic poke(input int a, input logic [71:0] w);
    @(negedge clk);
    bdWe = 1'b1; bdAddr = AW'(a); bdWdata = w;
    @(negedge clk);
    bdWe = 1'b0;
  endtask

  task automatic peek(input int a, output logic [71:0] w);
    @(negedge clk);
    bdAddr = AW'(a);
    #1;
    w = bdRdata;
  endtask

  task automatic clearFlags(input logic ce, input logic ue);
    @(negedge clk);
    clrCe = ce; clrUe = ue;
    @(negedge clk);
    clrCe = 1'b0; clrUe = 1'b0;
  endtask

  task automatic fullWrite(input int a, input logic [63:0] d, input string tag);
    doReq(1'b1, a, 8'hFF, d, '0, 1'b0, 1'b0, 1'b0, tag);
    shadow[a] = d;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [71:0] raw, orig;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset ready", 72'(reqReady), 72'd1);
    check("R1 reset rspValid", 72'(rspValid), 72'd0);
    check("R1 reset flags", 72'({stickyCe, stickyUe}), 72'd0);

    // R1: initialise every word with full writes, then read all back
    for (int a = 0; a < DEPTH; a++) fullWrite(a, pat(a), "R1 init");
    for (int a = 0; a < DEPTH; a++) doReq(1'b0, a, 8'h00, '0, shadow[a], 1'b0, 1'b0, 1'b1, "R1 read");
    fullWrite(1, 64'h0, "R1 zero");
    fullWrite(2, '1, "R1 ones");
    doReq(1'b0, 1, 8'h00, '0, 64'h0, 1'b0, 1'b0, 1'b1, "R1 zero data");
    doReq(1'b0, 2, 8'h00, '0, '1, 1'b0, 1'b0, 1'b1, "R1 ones data");
    settle();
    check("R1 flags clean", 72'({stickyCe, stickyUe}), 72'd0);

    // R2 / R5: single flip at every bit
    peek(3, orig);
    for (int k = 0; k < 72; k++) begin
      poke(3, orig ^ (72'd1 << k));
      doReq(1'b0, 3, 8'h00, '0, shadow[3], 1'b0, 1'b1, 1'b1, "R2 single flip");
      settle();
      peek(3, raw);
      check("R5 no read write-back", raw, orig ^ (72'd1 << k));
    end
    poke(3, orig);
    check("R2 stickyCe", 72'({stickyCe, stickyUe}), 72'b10);
    check("R9 first address", 72'(errAddr), 72'd3);
    clearFlags(1'b1, 1'b0);

    // R3: double flips across data, check and parity bits
    peek(4, orig);
    for (int k = 0; k < 72; k += 5) begin
      poke(4, orig ^ (72'd1 << k) ^ (72'd1 << ((k + 37) % 72)));
      doReq(1'b0, 4, 8'h00, '0, '0, 1'b1, 1'b0, 1'b0, "R3 double flip");
    end
    poke(4, orig ^ (72'd1 << 0) ^ (72'd1 << 71));
    doReq(1'b0, 4, 8'h00, '0, '0, 1'b1, 1'b0, 1'b0, "R3 double flip ends");
    settle();
    poke(4, orig);
    check("R3 stickyUe", 72'({stickyCe, stickyUe}), 72'b01);
    check("R9 address of double", 72'(errAddr), 72'd4);

    // R9: a later error at another address leaves errAddr alone
    peek(5, orig);
    poke(5, orig ^ (72'd1 << 20));
    doReq(1'b0, 5, 8'h00, '0, shadow[5], 1'b0, 1'b1, 1'b1, "R9 second error");
    settle();
    check("R9 address held", 72'(errAddr), 72'd4);
    // R10: clrUe clears only the UE flag
    clearFlags(1'b0, 1'b1);
    check("R10 clrUe only", 72'({stickyCe, stickyUe}), 72'b10);
    clearFlags(1'b1, 1'b0);
    check("R10 clrCe", 72'({stickyCe, stickyUe}), 72'b00);
    doReq(1'b0, 5, 8'h00, '0, shadow[5], 1'b0, 1'b1, 1'b1, "R9 recapture");
    settle();
    check("R9 recapture address", 72'(errAddr), 72'd5);
    poke(5, orig);
    clearFlags(1'b1, 1'b1);

    // R4: hard patterns
    poke(6, 72'h0);
    doReq(1'b0, 6, 8'h00, '0, '0, 1'b1, 1'b0, 1'b0, "R4 all zero");
    poke(6, '1);
    doReq(1'b0, 6, 8'h00, '0, '0, 1'b1, 1'b0, 1'b0, "R4 all one");
    settle();
    check("R4 stickyUe", 72'({stickyCe, stickyUe}), 72'b01);
    check("R4 address", 72'(errAddr), 72'd6);
    clearFlags(1'b1, 1'b1);
    fullWrite(6, pat(6), "R11 restore");

    // R6: clean partial writes
    begin
      logic [7:0] bes [4] = '{8'h01, 8'h80, 8'h7E, 8'h00};
      foreach (bes[i]) begin
        logic [63:0] nd;
        nd = 64'hA5A5_0F0F_3C3C_9999 ^ 64'(i * 64'h1111);
        doReq(1'b1, 7, bes[i], nd, '0, 1'b0, 1'b0, 1'b0, "R6 partial write");
        shadow[7] = mergeExp(shadow[7], nd, bes[i]);
        doReq(1'b0, 7, 8'h00, '0, shadow[7], 1'b0, 1'b0, 1'b1, "R6 merge result");
      end
    end
    settle();
    check("R6 flags clean", 72'({stickyCe, stickyUe}), 72'd0);

    // R7: correctable error repaired by the write-back
    peek(8, orig);
    poke(8, orig ^ (72'd1 << 10));
    doReq(1'b1, 8, 8'hF0, 64'hDEAD_BEEF_0000_0000, '0, 1'b0, 1'b1, 1'b0, "R7 rmw corrected");
    shadow[8] = mergeExp(shadow[8], 64'hDEAD_BEEF_0000_0000, 8'hF0);
    settle();
    check("R7 stickyCe", 72'({stickyCe, stickyUe}), 72'b10);
    doReq(1'b0, 8, 8'h00, '0, shadow[8], 1'b0, 1'b0, 1'b1, "R7 clean after repair");
    settle();
    clearFlags(1'b1, 1'b1);

    // R8: uncorrectable error aborts the write
    peek(9, orig);
    poke(9, orig ^ (72'd1 << 2) ^ (72'd1 << 40));
    doReq(1'b1, 9, 8'h0F, 64'h1234_5678_9ABC_DEF0, '0, 1'b1, 1'b0, 1'b0, "R8 rmw aborted");
    settle();
    peek(9, raw);
    check("R8 word unchanged", raw, orig ^ (72'd1 << 2) ^ (72'd1 << 40));
    check("R8 stickyUe", 72'({stickyCe, stickyUe}), 72'b01);
    check("R8 address", 72'(errAddr), 72'd9);
    clearFlags(1'b1, 1'b1);

    // R11: full write overrides a corrupted word without checking it
    poke(10, 72'h0);
    fullWrite(10, 64'h0BAD_F00D_CAFE_0001, "R11 full over hard word");
    doReq(1'b0, 10, 8'h00, '0, shadow[10], 1'b0, 1'b0, 1'b1, "R11 read back clean");
    settle();
    check("R11 no flags", 72'({stickyCe, stickyUe}), 72'd0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule